// File: doc/BRIEF.md
# Configurable Bidirectional GPIO Port

This block is an eight-bit general-purpose I/O port for a small microcontroller. The host writes through a simple strobe interface. It selects one of three registers: an output latch, a direction register and a control register. A parameter fixes at elaboration whether direction is held per bit or per four-bit nibble. One control bit switches every output bit between push-pull and open-drain drive.

Pin levels enter through a two-flop synchronizer. A read of the data register always returns these synchronized pin levels and never the output latch. An open-drain bit whose latch holds 1 releases its pad, so it reads back as whatever level is outside the chip. A host read-modify-write (AND, OR or XOR) uses the same pin levels as its source. The synchronized pins also feed two wake-up detectors: an eight-input AND and an eight-input OR. A stop-mode recovery strobe returns every bit to input.

Top module: `gpio_port8`

## Requirements
- R1: After an asserted `rst_n`, every bit is an input (`pad_oe` = 0), the output latch is 0, the direction register reads 0 and the control register reads 0 (push-pull).
- R2: With `reg_sel` = 0 (data), `rd_data` returns the pin levels as sampled through two flops. A change on `pad_in` shows after the second rising clock edge and not after the first. The output latch never appears on `rd_data`.
- R3: Direction register (`reg_sel` = 1, bit value 1 = output). In nibble mode bit 0 controls pins 3:0 and bit 1 controls pins 7:4. Written bits 7:2 are ignored and read back 0. In bit mode bit i controls pin i.
- R4: In push-pull mode (control bit 0 = 0), an output bit has `pad_oe` = 1 and `pad_do` equal to its latch bit.
- R5: In open-drain mode (control bit 0 = 1, `reg_sel` = 2), an output bit with latch 1 has `pad_oe` = 0. An output bit with latch 0 drives `pad_oe` = 1 with `pad_do` = 0. A released bit reads the external level.
- R6: `pad_pu` equals the `PULLUP_MASK` parameter with every output bit cleared.
- R7: `wake_all` is the AND of all eight synchronized pins and `wake_any` is their OR.
- R8: A strobe on `rmw_en` writes (synchronized pins OP `wr_data`) into the latch, with `rmw_op` 0 = AND, 1 = OR, 2 = XOR. A floating open-drain high bit that reads 0 is therefore written back as 0.
- R9: A pulse on `stop_rec` clears the direction register to all inputs. The output latch and the control register are kept.
- R10: `rmw_op` = 3 leaves the latch unchanged. Writes with `reg_sel` = 3 change nothing, and reads of that register return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 2 | Register select: 0 data, 1 direction, 2 control, 3 unused |
| wr_en | input | 1 | Write strobe for the selected register |
| wr_data | input | 8 | Write data, or operand of a read-modify-write |
| rmw_en | input | 1 | Read-modify-write strobe on the output latch |
| rmw_op | input | 2 | 0 AND, 1 OR, 2 XOR, 3 no operation |
| stop_rec | input | 1 | Stop-mode recovery strobe |
| pad_in | input | 8 | Pin levels from the pad input buffers |
| rd_data | output | 8 | Read value of the selected register |
| pad_oe | output | 8 | Pad output enables |
| pad_do | output | 8 | Pad output data |
| pad_pu | output | 8 | Pull-up enables |
| wake_all | output | 1 | All synchronized pins high |
| wake_any | output | 1 | Any synchronized pin high |

## Verification
The assertions assume that `rmw_en` and `wr_en` strobes last one cycle. They also assume that `stop_rec` may coincide with any write, and that recovery wins over a direction write. The stimulus therefore drives every strobe for exactly one clock, between falling edges. It never holds a strobe across two edges. It moves `pad_in` only at falling edges, so each synchronizer stage sees a settled level and the two-edge read latency can be counted exactly.

// File: rtl/gpio_port8.sv
module gpio_port8 #(
  parameter int          W           = 8,
  parameter int          NIB         = 4,
  parameter bit          NIBBLE_DIR  = 1'b1,
  parameter logic [7:0]  PULLUP_MASK = 8'hFF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   reg_sel,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rmw_en,
  input  logic [1:0]   rmw_op,
  input  logic         stop_rec,
  input  logic [W-1:0] pad_in,
  output logic [W-1:0] rd_data,
  output logic [W-1:0] pad_oe,
  output logic [W-1:0] pad_do,
  output logic [W-1:0] pad_pu,
  output logic         wake_all,
  output logic         wake_any
);
  localparam int NGRP = W / NIB;
  localparam int DW   = NIBBLE_DIR ? NGRP : W;
  localparam logic [1:0] SEL_DAT = 2'd0, SEL_DIR = 2'd1, SEL_CTL = 2'd2;

  logic [W-1:0]  pin_m, pin_q, dat_q, out_en;
  logic [DW-1:0] dir_q;
  logic          od_q;
  logic          host_wr;

  assign host_wr = wr_en && !rmw_en;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pin_m <= '0;
      pin_q <= '0;
    end else begin
      pin_m <= pad_in;
      pin_q <= pin_m;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) dir_q <= '0;
    else if (stop_rec) dir_q <= '0;
    else if (host_wr && reg_sel == SEL_DIR) dir_q <= wr_data[DW-1:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) od_q <= 1'b0;
    else if (host_wr && reg_sel == SEL_CTL) od_q <= wr_data[0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) dat_q <= '0;
    else if (rmw_en) begin
      case (rmw_op)
        2'd0:    dat_q <= pin_q & wr_data;
        2'd1:    dat_q <= pin_q | wr_data;
        2'd2:    dat_q <= pin_q ^ wr_data;
        default: dat_q <= dat_q;
      endcase
    end else if (wr_en && reg_sel == SEL_DAT) dat_q <= wr_data;

  generate
    if (NIBBLE_DIR) begin : g_nib
      for (genvar g = 0; g < NGRP; g++) begin : g_grp
        assign out_en[g*NIB +: NIB] = {NIB{dir_q[g]}};
      end
    end else begin : g_bit
      assign out_en = dir_q;
    end
  endgenerate

  assign pad_oe   = out_en & ~({W{od_q}} & dat_q);
  assign pad_do   = out_en & dat_q & ~{W{od_q}};
  assign pad_pu   = PULLUP_MASK[W-1:0] & ~out_en;
  assign wake_all = &pin_q;
  assign wake_any = |pin_q;

  always_comb
    case (reg_sel)
      SEL_DAT: rd_data = pin_q;
      SEL_DIR: rd_data = W'(dir_q);
      SEL_CTL: rd_data = W'(od_q);
      default: rd_data = '0;
    endcase

  AST_STOP_INPUT: assert property (@(posedge clk) disable iff (!rst_n) stop_rec |=> pad_oe == '0); // R9
  AST_PU_EXCL:    assert property (@(posedge clk) disable iff (!rst_n) (pad_pu & pad_oe) == '0); // R6
  AST_OD_NO_HIGH: assert property (@(posedge clk) disable iff (!rst_n) od_q |-> (pad_do & pad_oe) == '0); // R5
  AST_SYNC_DELAY: assert property (@(posedge clk) disable iff (!rst_n) pin_q == $past(pin_m)); // R2
  AST_WAKE_ORDER: assert property (@(posedge clk) disable iff (!rst_n) wake_all |-> wake_any); // R7
  AST_RMW_XOR:    assert property (@(posedge clk) disable iff (!rst_n)
                    (rmw_en && rmw_op == 2'd2) |=> dat_q == $past(pin_q ^ wr_data)); // R8
  AST_RMW_NOP:    assert property (@(posedge clk) disable iff (!rst_n)
                    (rmw_en && rmw_op == 2'd3) |=> $stable(dat_q)); // R10
endmodule

// File: tb/gpio_port8_tb.sv
module gpio_port8_tb_top;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic [1:0] reg_sel = 2'd0, rmw_op = 2'd0;
  logic       wr_en = 1'b0, rmw_en = 1'b0, stop_rec = 1'b0;
  logic [7:0] wr_data = 8'h00, pad_in = 8'h00;
  logic [7:0] rd_n, oe_n, do_n, pu_n, rd_b, oe_b, do_b, pu_b;
  logic       wa_n, wy_n, wa_b, wy_b;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  gpio_port8 #(.NIBBLE_DIR(1'b1), .PULLUP_MASK(8'hFF)) dut_i (
    .clk, .rst_n, .reg_sel, .wr_en, .wr_data, .rmw_en, .rmw_op, .stop_rec, .pad_in,
    .rd_data(rd_n), .pad_oe(oe_n), .pad_do(do_n), .pad_pu(pu_n), .wake_all(wa_n), .wake_any(wy_n));

  gpio_port8 #(.NIBBLE_DIR(1'b0), .PULLUP_MASK(8'h0F)) dut_bit_i (
    .clk, .rst_n, .reg_sel, .wr_en, .wr_data, .rmw_en, .rmw_op, .stop_rec, .pad_in,
    .rd_data(rd_b), .pad_oe(oe_b), .pad_do(do_b), .pad_pu(pu_b), .wake_all(wa_b), .wake_any(wy_b));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk); reg_sel = s; wr_data = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0; reg_sel = 2'd0;
  endtask

  task automatic rmw(input logic [1:0] op, input logic [7:0] d);
    @(negedge clk); rmw_op = op; wr_data = d; rmw_en = 1'b1;
    @(negedge clk); rmw_en = 1'b0;
  endtask

  task automatic pins(input logic [7:0] v);
    @(negedge clk); pad_in = v;
    repeat (2) @(negedge clk);
  endtask

  task automatic rd(input logic [1:0] s, input string req, input logic [7:0] en, input logic [7:0] eb);
    reg_sel = s; #1;
    chk({req, " nib rd"}, rd_n, en);
    chk({req, " bit rd"}, rd_b, eb);
    reg_sel = 2'd0;
  endtask

  task automatic t_reset;
    chk("R1 nib oe", oe_n, 8'h00); chk("R1 bit oe", oe_b, 8'h00);
    chk("R6 nib pu", pu_n, 8'hFF); chk("R6 bit pu", pu_b, 8'h0F);
    rd(2'd1, "R1 dir", 8'h00, 8'h00);
    rd(2'd2, "R1 ctl", 8'h00, 8'h00);
  endtask

  task automatic t_read_pins;
    wr(2'd0, 8'hA5);
    pins(8'h3C);
    rd(2'd0, "R2 pins", 8'h3C, 8'h3C);
    @(negedge clk); pad_in = 8'h81;
    @(negedge clk); rd(2'd0, "R2 one edge", 8'h3C, 8'h3C);
    @(negedge clk); rd(2'd0, "R2 two edges", 8'h81, 8'h81);
  endtask

  task automatic t_dir;
    wr(2'd1, 8'h03);
    chk("R3 nib oe", oe_n, 8'hFF); chk("R3 bit oe", oe_b, 8'h03);
    chk("R4 nib do", do_n, 8'hA5); chk("R4 bit do", do_b, 8'h01);
    rd(2'd1, "R3 dir", 8'h03, 8'h03);
    wr(2'd1, 8'hF1);
    rd(2'd1, "R10 dir upper", 8'h01, 8'hF1);
    chk("R3 nib oe low", oe_n, 8'h0F); chk("R3 bit oe F1", oe_b, 8'hF1);
    chk("R6 nib pu", pu_n, 8'hF0); chk("R6 bit pu", pu_b, 8'h0E);
    wr(2'd3, 8'hFF);
    rd(2'd3, "R10 sel3", 8'h00, 8'h00);
    rd(2'd1, "R10 sel3 dir", 8'h01, 8'hF1);
  endtask

  task automatic t_od;
    wr(2'd2, 8'h01);
    wr(2'd1, 8'hFF);
    chk("R5 nib oe", oe_n, 8'h5A); chk("R5 bit oe", oe_b, 8'h5A);
    chk("R5 nib do", do_n, 8'h00); chk("R5 bit do", do_b, 8'h00);
    pins(8'h00);
    rd(2'd0, "R5 released reads ext", 8'h00, 8'h00);
  endtask

  task automatic t_rmw;
    rmw(2'd1, 8'h00);
    chk("R8 od float nib oe", oe_n, 8'hFF); chk("R8 od float bit oe", oe_b, 8'hFF);
    wr(2'd2, 8'h00);
    pins(8'h0F);
    rmw(2'd2, 8'hFF);
    chk("R8 xor nib", do_n, 8'hF0); chk("R8 xor bit", do_b, 8'hF0);
    pins(8'h3C);
    rmw(2'd0, 8'h0F);
    chk("R8 and nib", do_n, 8'h0C); chk("R8 and bit", do_b, 8'h0C);
    rmw(2'd3, 8'hFF);
    chk("R10 nop nib", do_n, 8'h0C); chk("R10 nop bit", do_b, 8'h0C);
  endtask

  task automatic t_wake;
    pins(8'hFF);
    chk("R7 all ff", {6'd0, wa_n, wy_n}, 8'h03); chk("R7 bit ff", {6'd0, wa_b, wy_b}, 8'h03);
    pins(8'h10);
    chk("R7 one", {6'd0, wa_n, wy_n}, 8'h01);
    pins(8'h00);
    chk("R7 none", {6'd0, wa_n, wy_n}, 8'h00);
  endtask

  task automatic t_stop;
    wr(2'd2, 8'h01);
    @(negedge clk); stop_rec = 1'b1;
    @(negedge clk); stop_rec = 1'b0;
    chk("R9 nib oe", oe_n, 8'h00); chk("R9 bit oe", oe_b, 8'h00);
    chk("R9 nib pu", pu_n, 8'hFF);
    rd(2'd1, "R9 dir", 8'h00, 8'h00);
    rd(2'd2, "R9 ctl kept", 8'h01, 8'h01);
    wr(2'd1, 8'hFF);
    chk("R9 latch kept nib", oe_n, 8'hF3); chk("R9 latch kept bit", oe_b, 8'hF3);
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_read_pins;
    t_dir;
    t_od;
    t_rmw;
    t_wake;
    t_stop;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule